// File: doc/BRIEF.md
# Loopback Transfer-Group Chip-Select Sequencer

This controller sits inside a multi-buffer SPI slave and drives its self-test in I/O loopback mode. Software writes a 4-bit key into a small control word. The enabling key turns loopback on, latches which return path is used, and, with no external master, pulls the internal chip-select of transfer group 0 low so the slave's buffer engine starts that group.

The buffer engine pulses a done strobe each time it finishes one buffer and reports that buffer's address. When the finished buffer is the active group's last entry, the sequencer releases the chip-select. It then reads that entry's chip-select-number field from buffer RAM. If the value names an implemented, enabled group whose chip-select pin is functional, that group is triggered next. Otherwise the sequencer falls idle.

A group's last entry is the one just below the lowest start pointer, above its own, among the enabled groups. If no such start exists, it is the top entry of buffer RAM. The boundary is fixed when the group is triggered. The disabling key, or clearing every group enable, stops the sequence.

Top module: `lpbk_tg_seq`

## Requirements
- R1: After synchronous reset, `lpbk_on`, `busy`, `trig` and `buf_rd_en` are 0, `path_sel` is 2'b00 and every bit of `cs_n` is 1.
- R2: A write with `reg_wdata[3:0]` = 4'hA while loopback is off sets `lpbk_on` at that edge. `path_sel` is latched from the same write: 2'b01 digital when bit 4 is 0, 2'b10 analog through the transmit pad when bit 4 is 1 and bit 5 is 0, and 2'b11 analog through the receive pad when bits 4 and 5 are both 1. If group 0 is enabled and its pin is functional, the same edge also raises `trig`, sets `busy`, sets `active_grp` to 0 and drives `cs_n[0]` low; otherwise the sequencer stays idle.
- R3: A write with key 4'h5 clears `lpbk_on` and `busy`, sets `path_sel` to 2'b00 and drives all of `cs_n` high at that edge. It takes priority over every other event.
- R4: Writes with any other key change nothing. A 4'hA write while loopback is already on also changes nothing and triggers no group.
- R5: A done strobe whose `done_buf` differs from the active group's last entry leaves `cs_n`, `busy` and `active_grp` unchanged and issues no RAM read.
- R6: The last entry of a group is (lowest start pointer above the group's own start, among enabled groups) − 1, or NUM_BUFS−1 if there is none. It is evaluated when the group is triggered.
- R7: A done strobe for the last entry drives all of `cs_n` high at that edge and raises `buf_rd_en` for exactly one cycle with `buf_rd_addr` equal to that entry. The RAM returns `buf_rd_csn` one cycle after the read, and the next group's `trig` appears two edges after the done edge.
- R8: The returned chip-select number triggers that group only if it is below NUM_GROUPS, the group is enabled and its `cs_func_mask` bit is 1. Otherwise `busy` drops and `lpbk_on` stays 1.
- R9: If every bit of `grp_enable` is 0 while busy, the sequencer goes idle at the next edge with all of `cs_n` high.
- R10: At most one `cs_n` bit is low, only while `busy`; it is the `active_grp` bit, and every `trig` follows a cycle with all of `cs_n` high.
- R11: `trig` is a one-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Control word write strobe |
| reg_wdata | input | 6 | [3:0] key, [4] analog path, [5] receive-pad path |
| grp_start | input | NUM_GROUPS*BUF_AW | Start pointer per group, group g at [g*BUF_AW +: BUF_AW] |
| grp_enable | input | NUM_GROUPS | Group enable bits |
| cs_func_mask | input | NUM_GROUPS | Functional chip-select pins |
| xfer_done | input | 1 | Buffer finished strobe from the buffer engine |
| done_buf | input | BUF_AW | Address of the finished buffer |
| buf_rd_en | output | 1 | Buffer RAM read enable |
| buf_rd_addr | output | BUF_AW | Buffer RAM read address |
| buf_rd_csn | input | CSN_W | Chip-select-number field, one cycle after the read |
| lpbk_on | output | 1 | Loopback mode active |
| path_sel | output | 2 | Return path: 00 none, 01 digital, 10 transmit pad, 11 receive pad |
| busy | output | 1 | A group is running or its successor is being fetched |
| active_grp | output | GRP_AW | Index of the last triggered group |
| cs_n | output | NUM_GROUPS | Internal active-low chip-selects, one per group |
| trig | output | 1 | One-cycle pulse when a group is triggered |

## Verification
The bench builds the block with four groups, sixteen buffer entries and a 3-bit chip-select field. Values 4 to 7 of that field are therefore out of range, which exercises the idle path for out-of-range numbers. With starts at 0, 4, 8 and 12, switching group enables moves a group's last entry between its neighbour's start and the top of RAM, so both boundary cases of R6 can be reached. Chains that run across several groups, as well as stops by key, by disabled targets and by clearing all enables, all fit in short directed runs.

// File: rtl/lpbk_seq_pkg.sv
package lpbk_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_RUN    = 2'd1,
    ST_READ   = 2'd2,
    ST_DECIDE = 2'd3
  } seq_state_e;

  typedef enum logic [1:0] {
    PATH_NONE   = 2'b00,
    PATH_DIG    = 2'b01,
    PATH_ANA_TX = 2'b10,
    PATH_ANA_RX = 2'b11
  } lpbk_path_e;

  localparam logic [3:0] KEY_ON  = 4'hA;
  localparam logic [3:0] KEY_OFF = 4'h5;

  function automatic lpbk_path_e path_decode(input logic analog, input logic rx_pad);
    if (!analog) return PATH_DIG;
    return rx_pad ? PATH_ANA_RX : PATH_ANA_TX;
  endfunction

endpackage

// File: rtl/lpbk_ctrl_reg.sv
module lpbk_ctrl_reg
  import lpbk_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       reg_we,
  input  logic [5:0] reg_wdata,
  output logic       start_req,
  output logic       stop_req,
  output logic       lpbk_on,
  output logic [1:0] path_sel
);

  logic       on_q;
  lpbk_path_e path_q;
  logic [3:0] key;

  assign key       = reg_wdata[3:0];
  assign stop_req  = reg_we && (key == KEY_OFF);
  assign start_req = reg_we && (key == KEY_ON) && !on_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      on_q   <= 1'b0;
      path_q <= PATH_NONE;
    end else if (stop_req) begin
      on_q   <= 1'b0;
      path_q <= PATH_NONE;
    end else if (start_req) begin
      on_q   <= 1'b1;
      path_q <= path_decode(reg_wdata[4], reg_wdata[5]);
    end
  end

  assign lpbk_on  = on_q;
  assign path_sel = path_q;

endmodule

// File: rtl/lpbk_bound_calc.sv
module lpbk_bound_calc #(
  parameter int NUM_GROUPS = 8,
  parameter int NUM_BUFS   = 128,
  parameter int BUF_AW     = $clog2(NUM_BUFS),
  parameter int GRP_AW     = $clog2(NUM_GROUPS)
) (
  input  logic [NUM_GROUPS*BUF_AW-1:0] grp_start,
  input  logic [NUM_GROUPS-1:0]        grp_enable,
  input  logic [GRP_AW-1:0]            sel_grp,
  output logic [BUF_AW-1:0]            last_buf
);

  localparam int BW = BUF_AW + 1;

  logic [NUM_GROUPS*BUF_AW-1:0] last_flat;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_bound
    logic [BW-1:0] best;
    always_comb begin
      best = BW'(NUM_BUFS);
      for (int j = 0; j < NUM_GROUPS; j++) begin
        if (grp_enable[j]
            && (grp_start[j*BUF_AW +: BUF_AW] > grp_start[g*BUF_AW +: BUF_AW])
            && ({1'b0, grp_start[j*BUF_AW +: BUF_AW]} < best)) begin
          best = {1'b0, grp_start[j*BUF_AW +: BUF_AW]};
        end
      end
    end
    assign last_flat[g*BUF_AW +: BUF_AW] = BUF_AW'(best - BW'(1));
  end

  always_comb begin
    last_buf = '0;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      if (sel_grp == GRP_AW'(g)) last_buf = last_flat[g*BUF_AW +: BUF_AW];
    end
  end

endmodule

// File: rtl/lpbk_seq_fsm.sv
module lpbk_seq_fsm
  import lpbk_seq_pkg::*;
#(
  parameter int NUM_GROUPS = 8,
  parameter int BUF_AW     = 7,
  parameter int CSN_W      = 4,
  parameter int GRP_AW     = $clog2(NUM_GROUPS)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start_req,
  input  logic                  stop_req,
  input  logic [NUM_GROUPS-1:0] grp_enable,
  input  logic [NUM_GROUPS-1:0] cs_func_mask,
  input  logic                  xfer_done,
  input  logic [BUF_AW-1:0]     done_buf,
  input  logic [CSN_W-1:0]      buf_rd_csn,
  input  logic [BUF_AW-1:0]     last_buf_calc,
  output logic [GRP_AW-1:0]     cand_grp,
  output logic                  busy,
  output logic [GRP_AW-1:0]     active_grp,
  output logic [NUM_GROUPS-1:0] cs_n,
  output logic                  trig,
  output logic                  buf_rd_en,
  output logic [BUF_AW-1:0]     buf_rd_addr
);

  seq_state_e            state_q;
  logic [CSN_W-1:0]      cand;
  logic                  cand_in_range;
  logic                  cand_ok;
  logic [NUM_GROUPS-1:0] avail;
  logic [BUF_AW-1:0]     last_q;
  logic                  done_hit;

  // The candidate is group 0 for a fresh start, the fetched field otherwise.
  assign cand          = (state_q == ST_DECIDE) ? buf_rd_csn : '0;
  assign cand_grp      = cand[GRP_AW-1:0];
  assign cand_in_range = (32'(cand) < NUM_GROUPS);
  assign avail         = grp_enable & cs_func_mask;
  assign cand_ok       = cand_in_range && avail[cand_grp];
  assign done_hit      = xfer_done && (done_buf == last_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      busy       <= 1'b0;
      cs_n       <= '1;
      trig       <= 1'b0;
      buf_rd_en  <= 1'b0;
      active_grp <= '0;
      last_q     <= '0;
    end else begin
      trig      <= 1'b0;
      buf_rd_en <= 1'b0;
      if (stop_req) begin
        state_q <= ST_IDLE;
        busy    <= 1'b0;
        cs_n    <= '1;
      end else if (start_req) begin
        if (cand_ok) begin
          state_q    <= ST_RUN;
          busy       <= 1'b1;
          active_grp <= cand_grp;
          cs_n       <= ~(NUM_GROUPS'(1) << cand_grp);
          trig       <= 1'b1;
          last_q     <= last_buf_calc;
        end
      end else if (busy && (grp_enable == '0)) begin
        state_q <= ST_IDLE;
        busy    <= 1'b0;
        cs_n    <= '1;
      end else begin
        unique case (state_q)
          ST_RUN: begin
            if (done_hit) begin
              state_q   <= ST_READ;
              buf_rd_en <= 1'b1;
              cs_n      <= '1;
            end
          end
          ST_READ: state_q <= ST_DECIDE;
          ST_DECIDE: begin
            if (cand_ok) begin
              state_q    <= ST_RUN;
              active_grp <= cand_grp;
              cs_n       <= ~(NUM_GROUPS'(1) << cand_grp);
              trig       <= 1'b1;
              last_q     <= last_buf_calc;
            end else begin
              state_q <= ST_IDLE;
              busy    <= 1'b0;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign buf_rd_addr = last_q;

endmodule

// File: rtl/lpbk_tg_seq.sv
module lpbk_tg_seq #(
  parameter int NUM_GROUPS = 8,
  parameter int NUM_BUFS   = 128,
  parameter int CSN_W      = 4,
  localparam int BUF_AW    = $clog2(NUM_BUFS),
  localparam int GRP_AW    = $clog2(NUM_GROUPS)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         reg_we,
  input  logic [5:0]                   reg_wdata,
  input  logic [NUM_GROUPS*BUF_AW-1:0] grp_start,
  input  logic [NUM_GROUPS-1:0]        grp_enable,
  input  logic [NUM_GROUPS-1:0]        cs_func_mask,
  input  logic                         xfer_done,
  input  logic [BUF_AW-1:0]            done_buf,
  output logic                         buf_rd_en,
  output logic [BUF_AW-1:0]            buf_rd_addr,
  input  logic [CSN_W-1:0]             buf_rd_csn,
  output logic                         lpbk_on,
  output logic [1:0]                   path_sel,
  output logic                         busy,
  output logic [GRP_AW-1:0]            active_grp,
  output logic [NUM_GROUPS-1:0]        cs_n,
  output logic                         trig
);

  logic              start_req;
  logic              stop_req;
  logic [GRP_AW-1:0] cand_grp;
  logic [BUF_AW-1:0] last_buf_calc;

  lpbk_ctrl_reg u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata),
    .start_req (start_req),
    .stop_req  (stop_req),
    .lpbk_on   (lpbk_on),
    .path_sel  (path_sel)
  );

  lpbk_bound_calc #(
    .NUM_GROUPS (NUM_GROUPS),
    .NUM_BUFS   (NUM_BUFS),
    .BUF_AW     (BUF_AW),
    .GRP_AW     (GRP_AW)
  ) u_bound (
    .grp_start  (grp_start),
    .grp_enable (grp_enable),
    .sel_grp    (cand_grp),
    .last_buf   (last_buf_calc)
  );

  lpbk_seq_fsm #(
    .NUM_GROUPS (NUM_GROUPS),
    .BUF_AW     (BUF_AW),
    .CSN_W      (CSN_W),
    .GRP_AW     (GRP_AW)
  ) u_fsm (
    .clk           (clk),
    .rst           (rst),
    .start_req     (start_req),
    .stop_req      (stop_req),
    .grp_enable    (grp_enable),
    .cs_func_mask  (cs_func_mask),
    .xfer_done     (xfer_done),
    .done_buf      (done_buf),
    .buf_rd_csn    (buf_rd_csn),
    .last_buf_calc (last_buf_calc),
    .cand_grp      (cand_grp),
    .busy          (busy),
    .active_grp    (active_grp),
    .cs_n          (cs_n),
    .trig          (trig),
    .buf_rd_en     (buf_rd_en),
    .buf_rd_addr   (buf_rd_addr)
  );

endmodule

// File: rtl/lpbk_tg_seq_chk.sv
module lpbk_tg_seq_chk #(
  parameter int NUM_GROUPS = 8,
  localparam int GRP_AW    = $clog2(NUM_GROUPS)
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  reg_we,
  input logic [3:0]            key,
  input logic [NUM_GROUPS-1:0] grp_enable,
  input logic                  buf_rd_en,
  input logic                  lpbk_on,
  input logic                  busy,
  input logic [GRP_AW-1:0]     active_grp,
  input logic [NUM_GROUPS-1:0] cs_n,
  input logic                  trig
);

  // R10
  cs_onehot_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(~cs_n));

  // R10
  cs_idle_chk: assert property (@(posedge clk) disable iff (rst) !busy |-> (&cs_n));

  // R10
  trig_gap_chk: assert property (@(posedge clk) disable iff (rst) trig |-> $past(&cs_n));

  // R2
  trig_cs_chk: assert property (@(posedge clk) disable iff (rst) trig |-> (!cs_n[active_grp] && busy));

  // R11
  trig_pulse_chk: assert property (@(posedge clk) disable iff (rst) trig |=> !trig);

  // R3
  stop_key_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_we && key == 4'h5) |=> (!lpbk_on && !busy && (&cs_n)));

  // R3
  busy_needs_on_chk: assert property (@(posedge clk) disable iff (rst) busy |-> lpbk_on);

  // R7
  rd_pulse_chk: assert property (@(posedge clk) disable iff (rst) buf_rd_en |=> !buf_rd_en);

  // R9
  all_off_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && grp_enable == '0) |=> !busy);

endmodule

bind lpbk_tg_seq lpbk_tg_seq_chk #(.NUM_GROUPS(NUM_GROUPS)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .reg_we     (reg_we),
  .key        (reg_wdata[3:0]),
  .grp_enable (grp_enable),
  .buf_rd_en  (buf_rd_en),
  .lpbk_on    (lpbk_on),
  .busy       (busy),
  .active_grp (active_grp),
  .cs_n       (cs_n),
  .trig       (trig)
);

// File: tb/lpbk_tg_seq_tb.sv
module lpbk_tg_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NG  = 4;
  localparam int NB  = 16;
  localparam int CW  = 3;
  localparam int BAW = 4;
  localparam int GAW = 2;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            reg_we = 1'b0;
  logic [5:0]      reg_wdata = '0;
  logic [NG*BAW-1:0] grp_start = {4'd12, 4'd8, 4'd4, 4'd0};
  logic [NG-1:0]   grp_enable = 4'b1111;
  logic [NG-1:0]   cs_func_mask = 4'b1111;
  logic            xfer_done = 1'b0;
  logic [BAW-1:0]  done_buf = '0;
  logic            buf_rd_en;
  logic [BAW-1:0]  buf_rd_addr;
  logic [CW-1:0]   buf_rd_csn = '0;
  logic            lpbk_on;
  logic [1:0]      path_sel;
  logic            busy;
  logic [GAW-1:0]  active_grp;
  logic [NG-1:0]   cs_n;
  logic            trig;

  logic [CW-1:0]   mem [NB];
  int              n_checks = 0;
  int              n_fail = 0;
  logic            finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) if (buf_rd_en) buf_rd_csn <= mem[buf_rd_addr];

  lpbk_tg_seq #(.NUM_GROUPS(NG), .NUM_BUFS(NB), .CSN_W(CW)) u_dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .grp_start(grp_start), .grp_enable(grp_enable), .cs_func_mask(cs_func_mask),
    .xfer_done(xfer_done), .done_buf(done_buf), .buf_rd_en(buf_rd_en),
    .buf_rd_addr(buf_rd_addr), .buf_rd_csn(buf_rd_csn), .lpbk_on(lpbk_on),
    .path_sel(path_sel), .busy(busy), .active_grp(active_grp), .cs_n(cs_n),
    .trig(trig)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] key, input logic ana, input logic rx);
    @(negedge clk);
    reg_we = 1'b1;
    reg_wdata = {rx, ana, key};
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic done(input int b);
    @(negedge clk);
    xfer_done = 1'b1;
    done_buf = BAW'(b);
    @(negedge clk);
    xfer_done = 1'b0;
  endtask

  task automatic t_reset();
    check("R1", "lpbk_on", int'(lpbk_on), 0);
    check("R1", "busy", int'(busy), 0);
    check("R1", "cs_n", int'(cs_n), 15);
    check("R1", "path_sel", int'(path_sel), 0);
    check("R1", "trig/rd_en", int'({trig, buf_rd_en}), 0);
  endtask

  task automatic t_start();
    wr(4'hA, 1'b0, 1'b0);
    check("R2", "lpbk_on", int'(lpbk_on), 1);
    check("R2", "path_sel digital", int'(path_sel), 1);
    check("R2", "trig", int'(trig), 1);
    check("R2", "active_grp", int'(active_grp), 0);
    check("R10", "cs_n grp0", int'(cs_n), 14);
    @(negedge clk);
    check("R11", "trig pulse", int'(trig), 0);
  endtask

  task automatic t_inner_done();
    done(1);
    check("R5", "busy", int'(busy), 1);
    check("R5", "cs_n", int'(cs_n), 14);
    check("R5", "rd_en", int'(buf_rd_en), 0);
  endtask

  task automatic t_advance();
    grp_enable = 4'b0111;
    done(3);
    check("R7", "cs_n released", int'(cs_n), 15);
    check("R7", "rd_en", int'(buf_rd_en), 1);
    check("R7", "rd_addr", int'(buf_rd_addr), 3);
    check("R7", "busy", int'(busy), 1);
    @(negedge clk);
    check("R7", "rd_en single", int'(buf_rd_en), 0);
    check("R7", "no early trig", int'(trig), 0);
    @(negedge clk);
    check("R8", "trig next", int'(trig), 1);
    check("R8", "active_grp", int'(active_grp), 2);
    check("R10", "cs_n grp2", int'(cs_n), 11);
  endtask

  task automatic t_skip_boundary();
    done(11);
    check("R6", "buf 11 not last", int'(buf_rd_en), 0);
    check("R6", "cs_n kept", int'(cs_n), 11);
    done(15);
    check("R6", "rd_addr top", int'(buf_rd_addr), 15);
    check("R6", "rd_en", int'(buf_rd_en), 1);
    repeat (2) @(negedge clk);
    check("R8", "active grp1", int'(active_grp), 1);
    check("R8", "cs_n grp1", int'(cs_n), 13);
    done(7);
    check("R6", "grp1 last 7", int'(buf_rd_addr), 7);
    repeat (2) @(negedge clk);
    check("R8", "out of range idle", int'(busy), 0);
    check("R8", "cs_n idle", int'(cs_n), 15);
    check("R8", "lpbk stays on", int'(lpbk_on), 1);
  endtask

  task automatic t_keys();
    wr(4'hA, 1'b1, 1'b1);
    check("R4", "re-enable no trig", int'({trig, busy}), 0);
    check("R4", "path unchanged", int'(path_sel), 1);
    wr(4'h7, 1'b0, 1'b0);
    check("R4", "other key", int'(lpbk_on), 1);
    wr(4'h5, 1'b0, 1'b0);
    check("R3", "off", int'(lpbk_on), 0);
    check("R3", "path none", int'(path_sel), 0);
    wr(4'h3, 1'b0, 1'b0);
    check("R4", "other key off", int'(lpbk_on), 0);
  endtask

  task automatic t_disabled_target();
    grp_enable = 4'b1011;
    wr(4'hA, 1'b1, 1'b1);
    check("R2", "path rx pad", int'(path_sel), 3);
    check("R2", "trig grp0", int'({trig, active_grp}), 4);
    done(3);
    repeat (2) @(negedge clk);
    check("R8", "disabled target idle", int'(busy), 0);
    check("R8", "no trig", int'(trig), 0);
  endtask

  task automatic t_mask();
    wr(4'h5, 1'b0, 1'b0);
    grp_enable = 4'b1111;
    cs_func_mask = 4'b1110;
    wr(4'hA, 1'b1, 1'b0);
    check("R2", "path tx pad", int'(path_sel), 2);
    check("R2", "on without trigger", int'(lpbk_on), 1);
    check("R8", "pin not functional", int'({busy, trig}), 0);
    cs_func_mask = 4'b1111;
  endtask

  task automatic t_stop_mid();
    wr(4'h5, 1'b0, 1'b0);
    wr(4'hA, 1'b0, 1'b0);
    check("R2", "busy", int'(busy), 1);
    wr(4'h9, 1'b0, 1'b0);
    check("R4", "key 9 run kept", int'(cs_n), 14);
    wr(4'h5, 1'b0, 1'b0);
    check("R3", "stop busy", int'(busy), 0);
    check("R3", "stop cs_n", int'(cs_n), 15);
  endtask

  task automatic t_all_off();
    wr(4'hA, 1'b0, 1'b0);
    @(negedge clk);
    grp_enable = 4'b0000;
    @(negedge clk);
    check("R9", "idle", int'(busy), 0);
    check("R9", "cs_n", int'(cs_n), 15);
    grp_enable = 4'b1111;
  endtask

  task automatic t_last_group();
    mem[3] = 3'd3;
    wr(4'h5, 1'b0, 1'b0);
    wr(4'hA, 1'b0, 1'b0);
    done(3);
    repeat (2) @(negedge clk);
    check("R8", "grp3", int'(active_grp), 3);
    check("R10", "cs_n grp3", int'(cs_n), 7);
    done(15);
    check("R6", "last grp top entry", int'(buf_rd_addr), 15);
    repeat (2) @(negedge clk);
    check("R8", "chain to grp1", int'(active_grp), 1);
    wr(4'h5, 1'b0, 1'b0);
  endtask

  initial begin
    for (int i = 0; i < NB; i++) mem[i] = 3'd0;
    mem[3] = 3'd2;
    mem[7] = 3'd6;
    mem[15] = 3'd1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_start();
    t_inner_done();
    t_advance();
    t_skip_boundary();
    t_keys();
    t_disabled_target();
    t_mask();
    t_stop_mid();
    t_all_off();
    t_last_group();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

endmodule